// File: doc/BRIEF.md
# Page Shadow Check-Target Resolver

This block finds the check handler that governs a target address. It uses a shadow table with one 16-bit entry for each 4096-byte page. For each lookup request, the block sends the page index of the target address straight to the read port of an external synchronous shadow memory. On the next cycle it decodes the entry that comes back. An entry can mean one of three things:

- the target is invalid;
- the target belongs to a trusted module that runs without checks;
- the target belongs to an instrumented module. In this case the entry holds the handler's distance, counted in pages, below the target page's upper boundary. The block turns that distance back into a full handler address.

The shadow table is normally treated as read-only. A write path passes through the block, and it reaches the memory only while an unlock input is high. Requests can be issued back to back, one per cycle. Each result comes with a done pulse at a fixed latency.

Top module: `pgs_resolver`

## Requirements
- R1: In the same cycle as a request, the block drives `mem_rd_en` high and drives `mem_rd_idx` with the request address shifted right by 12 bits.
- R2: `res_done` is high for exactly one cycle, in the cycle after the second rising clock edge that follows a sampled request. A new request can be accepted on every cycle.
- R3: A table entry of 16'h0000 returns class code 2'b00 (invalid) and a handler address of 0.
- R4: A table entry of 16'hFFFF returns class code 2'b01 (unchecked) and a handler address of 0.
- R5: Any other entry V returns class code 2'b10 (instrumented). The handler address is the target rounded up to a multiple of 4096, minus (V+1)*4096, taken modulo 2^ADDR_W.
- R6: The rounding rule works as follows. A target whose low 12 bits are zero rounds up to itself. Any nonzero low bits round up to the next page. Rounding past the top page wraps to page 0.
- R7: `mem_wr_en` follows `tbl_wr_en` only while `tbl_unlock` is high. A write attempted while the table is locked leaves the table content unchanged. The write index and data are passed through unchanged.
- R8: `res_class` and `res_handler` keep their values in every cycle where `res_done` is low.
- R9: After reset, `res_done`, `res_class` and `res_handler` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Target address to resolve |
| mem_rd_en | output | 1 | Shadow memory read enable |
| mem_rd_idx | output | ADDR_W-12 | Shadow memory page index |
| mem_rd_data | input | ENTRY_W | Entry returned one cycle after the read |
| tbl_unlock | input | 1 | Permits table updates while high |
| tbl_wr_en | input | 1 | Table update request |
| tbl_wr_idx | input | ADDR_W-12 | Page index to update |
| tbl_wr_data | input | ENTRY_W | New entry value |
| mem_wr_en | output | 1 | Gated shadow memory write enable |
| mem_wr_idx | output | ADDR_W-12 | Shadow memory write index |
| mem_wr_data | output | ENTRY_W | Shadow memory write data |
| res_done | output | 1 | One-cycle result strobe |
| res_class | output | 2 | 00 invalid, 01 unchecked, 10 instrumented |
| res_handler | output | ADDR_W | Handler address, 0 unless instrumented |

## Verification
The bench runs a small configuration with 256 pages. It fills every page with entries from a fixed pattern that contains zero, all-ones, a near-maximum delta and assorted small deltas. It then looks up each page three times: at the page base, one byte in, and at the last byte. This separates the case where the address is already aligned from the round-up case, and it exercises wraparound at the top page. A locked write followed by an unlocked write to the same page shows whether the unlock gate actually blocks updates. A burst of back-to-back requests shows whether results stay paired with the right requests when the pipeline is full.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    PGS_INVALID   = 2'b00,
    PGS_UNCHECKED = 2'b01,
    PGS_INSTR     = 2'b10
  } pgs_class_e;
endpackage

// File: rtl/pgs_rst_sync.sv
module pgs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign sync_d[s] = 1'b1;
      end else begin : g_next
        assign sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pgs_capture.sv
module pgs_capture #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr
);
  logic              valid_d;
  logic              valid_q;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    valid_d = req_valid;
    addr_en = req_valid;
    addr_d  = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign cap_valid = valid_q;
  assign cap_addr  = addr_q;
endmodule

// File: rtl/pgs_decode.sv
module pgs_decode
  import pgs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRY_W = 16
) (
  input  logic [ADDR_W-1:0]  tgt_addr,
  input  logic [ENTRY_W-1:0] entry,
  output pgs_class_e         cls,
  output logic [ADDR_W-1:0]  handler
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int unsigned CALC_W = ((PAGE_W > ENTRY_W) ? PAGE_W : ENTRY_W) + 1;
  localparam logic [ENTRY_W-1:0] UNCHK_VAL = {ENTRY_W{1'b1}};

  logic [PAGE_W-1:0] page;
  logic              low_nz;
  logic [CALC_W-1:0] page_up;
  logic [CALC_W-1:0] back_pages;
  logic [CALC_W-1:0] hnd_page;

  always_comb begin
    page       = tgt_addr[ADDR_W-1:PAGE_SHIFT];
    low_nz     = |tgt_addr[PAGE_SHIFT-1:0];
    page_up    = CALC_W'(page) + CALC_W'(low_nz);
    back_pages = CALC_W'(entry) + CALC_W'(1);
    hnd_page   = page_up - back_pages;

    if (entry == '0) begin
      cls     = PGS_INVALID;
      handler = '0;
    end else if (entry == UNCHK_VAL) begin
      cls     = PGS_UNCHECKED;
      handler = '0;
    end else begin
      cls     = PGS_INSTR;
      handler = {hnd_page[PAGE_W-1:0], {PAGE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/pgs_result.sv
module pgs_result
  import pgs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pgs_class_e        cls_in,
  input  logic [ADDR_W-1:0] handler_in,
  output logic              done,
  output pgs_class_e        cls_out,
  output logic [ADDR_W-1:0] handler_out
);
  logic              done_d;
  logic              done_q;
  logic              res_en;
  pgs_class_e        cls_d;
  pgs_class_e        cls_q;
  logic [ADDR_W-1:0] hnd_d;
  logic [ADDR_W-1:0] hnd_q;

  always_comb begin
    done_d = load;
    res_en = load;
    cls_d  = cls_in;
    hnd_d  = handler_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cls_q  <= PGS_INVALID;
      hnd_q  <= '0;
    end else begin
      done_q <= done_d;
      if (res_en) begin
        cls_q <= cls_d;
        hnd_q <= hnd_d;
      end
    end
  end

  assign done        = done_q;
  assign cls_out     = cls_q;
  assign handler_out = hnd_q;
endmodule

// File: rtl/pgs_resolver.sv
module pgs_resolver
  import pgs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned ENTRY_W     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               mem_rd_en,
  output logic [PAGE_W-1:0]  mem_rd_idx,
  input  logic [ENTRY_W-1:0] mem_rd_data,
  input  logic               tbl_unlock,
  input  logic               tbl_wr_en,
  input  logic [PAGE_W-1:0]  tbl_wr_idx,
  input  logic [ENTRY_W-1:0] tbl_wr_data,
  output logic               mem_wr_en,
  output logic [PAGE_W-1:0]  mem_wr_idx,
  output logic [ENTRY_W-1:0] mem_wr_data,
  output logic               res_done,
  output logic [1:0]         res_class,
  output logic [ADDR_W-1:0]  res_handler
);
  logic              rst_sync_n;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  pgs_class_e        dec_cls;
  logic [ADDR_W-1:0] dec_handler;
  pgs_class_e        out_cls;

  pgs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // read issue goes straight to the memory; its output register is the first stage
  assign mem_rd_en  = req_valid;
  assign mem_rd_idx = req_addr[ADDR_W-1:PAGE_SHIFT];

  // table updates pass only while unlocked
  assign mem_wr_en   = tbl_wr_en & tbl_unlock;
  assign mem_wr_idx  = tbl_wr_idx;
  assign mem_wr_data = tbl_wr_data;

  pgs_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr)
  );

  pgs_decode #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_dec (
    .tgt_addr (cap_addr),
    .entry    (mem_rd_data),
    .cls      (dec_cls),
    .handler  (dec_handler)
  );

  pgs_result #(.ADDR_W(ADDR_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load        (cap_valid),
    .cls_in      (dec_cls),
    .handler_in  (dec_handler),
    .done        (res_done),
    .cls_out     (out_cls),
    .handler_out (res_handler)
  );

  assign res_class = out_cls;
endmodule

// File: rtl/pgs_resolver_chk.sv
module pgs_resolver_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              tbl_unlock,
  input logic              mem_wr_en,
  input logic              res_done,
  input logic [1:0]        res_class,
  input logic [ADDR_W-1:0] res_handler
);
  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 res_done);

  // R2
  done_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_done) |-> $past(req_valid, 2));

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_unlock |-> !mem_wr_en);

  // R3
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_class == 2'b00) |-> (res_handler == '0));

  // R4
  unchecked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_class == 2'b01) |-> (res_handler == '0));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_class) && $stable(res_handler)));
endmodule

bind pgs_resolver pgs_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .tbl_unlock  (tbl_unlock),
  .mem_wr_en   (mem_wr_en),
  .res_done    (res_done),
  .res_class   (res_class),
  .res_handler (res_handler)
);

// File: tb/pgs_resolver_tb_top.sv
module pgs_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int ENTRY_W    = 16;
  localparam int PAGE_W     = ADDR_W - 12;
  localparam int PAGES      = 1 << PAGE_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid;
  logic [ADDR_W-1:0]  req_addr;
  logic               mem_rd_en;
  logic [PAGE_W-1:0]  mem_rd_idx;
  logic [ENTRY_W-1:0] mem_rd_data;
  logic               tbl_unlock;
  logic               tbl_wr_en;
  logic [PAGE_W-1:0]  tbl_wr_idx;
  logic [ENTRY_W-1:0] tbl_wr_data;
  logic               mem_wr_en;
  logic [PAGE_W-1:0]  mem_wr_idx;
  logic [ENTRY_W-1:0] mem_wr_data;
  logic               res_done;
  logic [1:0]         res_class;
  logic [ADDR_W-1:0]  res_handler;

  logic [ENTRY_W-1:0] ram [PAGES];
  logic [ENTRY_W-1:0] model [PAGES];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_wr_en) ram[mem_wr_idx] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= ram[mem_rd_idx];
  end

  pgs_resolver #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
    .tbl_unlock(tbl_unlock), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .mem_wr_en(mem_wr_en), .mem_wr_idx(mem_wr_idx), .mem_wr_data(mem_wr_data),
    .res_done(res_done), .res_class(res_class), .res_handler(res_handler)
  );

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] pattern(int i);
    case (i % 8)
      0: return 16'h0000;
      1: return 16'hFFFF;
      7: return 16'hFFFE;
      default: return 16'((i * 29 + 3) % 256);
    endcase
  endfunction

  function automatic int exp_class(logic [ENTRY_W-1:0] v);
    if (v == 16'h0000) return 0;
    if (v == 16'hFFFF) return 1;
    return 2;
  endfunction

  function automatic longint exp_handler(logic [ADDR_W-1:0] a, logic [ENTRY_W-1:0] v);
    longint pu;
    longint hp;
    if (exp_class(v) != 2) return 0;
    pu = longint'(a >> 12) + ((a[11:0] != 0) ? 1 : 0);
    hp = (pu - (longint'(v) + 1)) & (PAGES - 1);
    return hp << 12;
  endfunction

  task automatic write_entry(int idx, logic [ENTRY_W-1:0] val, bit unlock);
    @(negedge clk);
    tbl_wr_en   = 1'b1;
    tbl_wr_idx  = PAGE_W'(idx);
    tbl_wr_data = val;
    tbl_unlock  = unlock;
    #1;
    check("R7 write gate", mem_wr_en, unlock);
    if (unlock) begin
      check("R7 write index", mem_wr_idx, idx);
      check("R7 write data", mem_wr_data, val);
      model[idx] = val;
    end
    @(negedge clk);
    tbl_wr_en  = 1'b0;
    tbl_unlock = 1'b0;
  endtask

  task automatic lookup(logic [ADDR_W-1:0] a, string tag);
    logic [ENTRY_W-1:0] v;
    int ec;
    v  = model[a >> 12];
    ec = exp_class(v);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    check("R1 read enable", mem_rd_en, 1);
    check("R1 read index", mem_rd_idx, a >> 12);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 early done", res_done, 0);
    @(negedge clk);
    check("R2 done pulse", res_done, 1);
    if (ec == 0) check({"R3 class ", tag}, res_class, 0);
    else if (ec == 1) check({"R4 class ", tag}, res_class, 1);
    else check({"R5 class ", tag}, res_class, 2);
    check({"R5 R6 handler ", tag}, res_handler, exp_handler(a, v));
    @(negedge clk);
    check("R2 single pulse", res_done, 0);
    check("R8 class held", res_class, ec);
    check("R8 handler held", res_handler, exp_handler(a, v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] ba [4];
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0;
    tbl_unlock = 1'b0; tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
    for (int i = 0; i < PAGES; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset done", res_done, 0);
    check("R9 reset class", res_class, 0);
    check("R9 reset handler", res_handler, 0);

    for (int i = 0; i < PAGES; i++) write_entry(i, pattern(i), 1'b1);

    // R6: aligned, one byte in, last byte of each page
    for (int i = 0; i < PAGES; i++) begin
      lookup(ADDR_W'(i << 12), "base");
      lookup(ADDR_W'((i << 12) + 1), "plus1");
      lookup(ADDR_W'((i << 12) + 12'hFFF), "last");
    end

    // R7: locked write leaves page 2 unchanged, unlocked one replaces it
    write_entry(2, 16'h0000, 1'b0);
    lookup(ADDR_W'(20'h02010), "locked");
    write_entry(2, 16'h0004, 1'b1);
    lookup(ADDR_W'(20'h02010), "unlocked");

    // R2: back-to-back burst
    for (int k = 0; k < 4; k++) ba[k] = ADDR_W'(((10 + k) << 12) + 12'h800);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k < 4) begin req_valid = 1'b1; req_addr = ba[k]; end
      else req_valid = 1'b0;
      if (k >= 2) begin
        check("R2 burst done", res_done, 1);
        check("R5 burst class", res_class, exp_class(model[ba[k-2] >> 12]));
        check("R5 burst handler", res_handler, exp_handler(ba[k-2], model[ba[k-2] >> 12]));
      end
    end
    @(negedge clk);
    check("R2 burst end", res_done, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule